// File: doc/BRIEF.md
# Packet Header Trace Filter

This block sits between a capture point on a PCIe link and the writer that stores trace records in memory. For every transaction-layer packet header offered to it, it decides whether the header belongs in the trace. It bases that decision on a 32-bit control word that software programs: an enable, a packet-class selection, a direction code, a record width and a filter target. A header that passes is copied into a local record holder. The block then streams it out one 32-bit dword per beat, on a valid/ready interface. A record is 4 dwords or 8 dwords long.

The filter target works in one of two modes. In port mode it is a bitmask of root ports, and each port owns an even bit position. In requester mode it is one 16-bit requester ID that must match exactly. The direction code means different things at the two record widths. Any configuration that is reserved or unsupported passes nothing.

The emitter is a two-state machine. ST_IDLE is ready for a header. Its transition "drop" stays in ST_IDLE when the offered header fails the filter. Its transition "accept" moves to ST_SEND when the header passes; this also latches the header words and the record length. In ST_SEND, the transition "advance" steps to the next dword on each accepted beat. The transition "finish" returns to ST_IDLE after the last dword is taken. Headers are emitted strictly in arrival order, and no new header is taken while a record is still going out.

Top module: `tlp_trace_filter`

## Requirements
- R1: After reset, out_valid is 0 and hdr_ready is 1.
- R2: When control bit 0 (trace enable) is 0, no offered header produces any output.
- R3: Control bits [7:4] form a multi-hot class select: bit 4 passes posted (class code 0), bit 5 passes non-posted (code 1), bit 6 passes completions (code 2). Class code 3 never passes. If bit 7 is set, nothing passes.
- R4: Control bit 14 sets the record width: 0 emits header words 0..3, 1 emits words 0..7. Words come out in index order, and out_last is high only on the final dword.
- R5: When control bit 15 is 1, a header passes only if hdr_rid equals control bits [31:16] exactly.
- R6: When control bit 15 is 0, a header passes only if control bit 16 + ((hdr_port & 7) << 1) is set.
- R7: At 4-dword width, hdr_dir 0 means inbound and 1 means outbound. Direction code (bits [3:2]) 0 passes inbound only, 1 passes outbound only, and 2 or 3 pass both directions.
- R8: At 8-dword width, direction codes 0 and 1 pass nothing. Code 2 passes inbound posted and non-posted requests only. Code 3 passes inbound completions only.
- R9: hdr_ready is low while a record is being emitted. While out_valid is high and out_ready is low, out_valid, out_data and out_last hold their values.
- R10: The record length and contents are fixed when the header is accepted. Changing the control word or header inputs afterwards does not alter the record. After the last beat, the block returns to ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ctrl | input | 32 | Control word |
| hdr_valid | input | 1 | Header offered this cycle |
| hdr_ready | output | 1 | Block can take a header |
| hdr_dir | input | 1 | 0 inbound, 1 outbound |
| hdr_class | input | 2 | 0 posted, 1 non-posted, 2 completion, 3 other |
| hdr_port | input | PORT_W | Root-port slot number the packet crossed |
| hdr_rid | input | 16 | Requester ID |
| hdr_words | input | MAX_WORDS*DW | Header dwords, word 0 in the low bits |
| out_valid | output | 1 | Record dword valid |
| out_ready | input | 1 | Downstream takes the dword |
| out_data | output | DW | Record dword |
| out_last | output | 1 | Final dword of the record |

## Verification
The bench builds the block with DW=32, MAX_WORDS=8 and PORT_W=4. The 4-bit port number lets slot values above 7 reach the design, which exercises the wrap of the port index to three bits before it is doubled. With eight header words, both record widths can be checked dword by dword against the full header. Random out_ready stalls are applied in the middle of records, and the control word is scrambled right after each accept, so the holding and latching rules are tested on every record.

// File: rtl/tlp_filt_pkg.sv
package tlp_filt_pkg;

    typedef enum logic [1:0] {
        CLS_POSTED    = 2'd0,
        CLS_NONPOSTED = 2'd1,
        CLS_COMPL     = 2'd2,
        CLS_OTHER     = 2'd3
    } pkt_class_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } emit_state_e;

    typedef struct packed {
        logic [15:0] target;
        logic        rid_mode;
        logic        wide;
        logic [3:0]  cls_sel;
        logic [1:0]  dir_sel;
        logic        en;
    } cfg_t;

    function automatic cfg_t unpack_cfg(input logic [31:0] w);
        cfg_t c;
        c.en       = w[0];
        c.dir_sel  = w[3:2];
        c.cls_sel  = w[7:4];
        c.wide     = w[14];
        c.rid_mode = w[15];
        c.target   = w[31:16];
        return c;
    endfunction

endpackage

// File: rtl/tlp_filt_match.sv
module tlp_filt_match
    import tlp_filt_pkg::*;
#(
    parameter int PORT_W = 4
) (
    input  cfg_t              cfg,
    input  logic              dir_out,
    input  logic [1:0]        cls,
    input  logic [PORT_W-1:0] port,
    input  logic [15:0]       rid,
    output logic              pass
);
    logic       class_ok;
    logic       target_ok;
    logic       dir_ok;
    logic [3:0] port_bit;

    always_comb begin
        class_ok = (cls != CLS_OTHER) && !cfg.cls_sel[3] && cfg.cls_sel[cls];
    end

    always_comb begin
        port_bit  = {port[2:0], 1'b0};
        target_ok = cfg.rid_mode ? (rid == cfg.target) : cfg.target[port_bit];
    end

    always_comb begin
        dir_ok = 1'b0;
        if (!cfg.wide) begin
            unique case (cfg.dir_sel)
                2'd0:    dir_ok = !dir_out;
                2'd1:    dir_ok = dir_out;
                default: dir_ok = 1'b1;
            endcase
        end else begin
            unique case (cfg.dir_sel)
                2'd2:    dir_ok = !dir_out && (cls != CLS_COMPL);
                2'd3:    dir_ok = !dir_out && (cls == CLS_COMPL);
                default: dir_ok = 1'b0;
            endcase
        end
    end

    assign pass = cfg.en && class_ok && target_ok && dir_ok;

endmodule

// File: rtl/tlp_filt_emit.sv
module tlp_filt_emit
    import tlp_filt_pkg::*;
#(
    parameter int DW        = 32,
    parameter int MAX_WORDS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic                    wide,
    input  logic [MAX_WORDS*DW-1:0] words,
    output logic                    in_ready,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [DW-1:0]           out_data,
    output logic                    out_last
);
    localparam int CNT_W = $clog2(MAX_WORDS);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(MAX_WORDS - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(MAX_WORDS / 2 - 1);

    emit_state_e      state_q, state_nx;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_q;
    logic [DW-1:0]    rec_q [MAX_WORDS];
    logic             at_last;

    assign at_last = (cnt_q == last_q);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (take) state_nx = ST_SEND;
            ST_SEND: if (out_ready && at_last) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= LAST_SHORT;
        end else if (state_q == ST_IDLE && take) begin
            cnt_q  <= '0;
            last_q <= wide ? LAST_LONG : LAST_SHORT;
        end else if (state_q == ST_SEND && out_ready && !at_last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (state_q == ST_IDLE && take) begin
            for (int i = 0; i < MAX_WORDS; i++)
                rec_q[i] <= words[i*DW +: DW];
        end
    end

    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        out_valid = (state_q == ST_SEND);
        out_data  = rec_q[cnt_q];
        out_last  = (state_q == ST_SEND) && at_last;
    end

    // R9: a stalled beat holds everything
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R9: no intake while emitting
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R4: a record never starts on its last dword
    p_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> !out_last);

    // R10: after the final beat the block is ready again
    p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

endmodule

// File: rtl/tlp_trace_filter.sv
module tlp_trace_filter
    import tlp_filt_pkg::*;
#(
    parameter int DW        = 32,
    parameter int MAX_WORDS = 8,
    parameter int PORT_W    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [31:0]             cfg_ctrl,
    input  logic                    hdr_valid,
    output logic                    hdr_ready,
    input  logic                    hdr_dir,
    input  logic [1:0]              hdr_class,
    input  logic [PORT_W-1:0]       hdr_port,
    input  logic [15:0]             hdr_rid,
    input  logic [MAX_WORDS*DW-1:0] hdr_words,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [DW-1:0]           out_data,
    output logic                    out_last
);
    cfg_t cfg;
    logic pass;
    logic take;

    assign cfg  = unpack_cfg(cfg_ctrl);
    assign take = hdr_valid && pass;

    tlp_filt_match #(.PORT_W(PORT_W)) u_match (
        .cfg     (cfg),
        .dir_out (hdr_dir),
        .cls     (hdr_class),
        .port    (hdr_port),
        .rid     (hdr_rid),
        .pass    (pass)
    );

    tlp_filt_emit #(.DW(DW), .MAX_WORDS(MAX_WORDS)) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .wide      (cfg.wide),
        .words     (hdr_words),
        .in_ready  (hdr_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    // R2: disabled tracing yields no record
    p_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready && !cfg_ctrl[0]) |=> !out_valid);

    // R8: wide format with direction code 0 or 1 yields no record
    p_wide_rsv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready && cfg_ctrl[14] && !cfg_ctrl[3]) |=> !out_valid);

    // R1: an idle emitter always accepts headers
    p_idle_rdy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> hdr_ready);

endmodule

// File: tb/tlp_trace_filter_tb.sv
module tlp_trace_filter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int MW = 8;
    localparam int PW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       cfg_ctrl = '0;
    logic              hdr_valid = 1'b0;
    logic              hdr_ready;
    logic              hdr_dir = 1'b0;
    logic [1:0]        hdr_class = '0;
    logic [PW-1:0]     hdr_port = '0;
    logic [15:0]       hdr_rid = '0;
    logic [MW*DW-1:0]  hdr_words = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [DW-1:0]     out_data;
    logic              out_last;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlp_trace_filter #(.DW(DW), .MAX_WORDS(MW), .PORT_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_dir(hdr_dir),
        .hdr_class(hdr_class), .hdr_port(hdr_port), .hdr_rid(hdr_rid),
        .hdr_words(hdr_words), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_pass(input logic [31:0] c, input bit dout,
                                    input logic [1:0] cls, input logic [PW-1:0] port,
                                    input logic [15:0] rid);
        int pb;
        if (!c[0]) return 1'b0;
        if (cls == 2'd3 || c[7] || !c[4 + int'(cls)]) return 1'b0;
        pb = 16 + 2 * int'(port[2:0]);
        if (c[15]) begin
            if (rid != c[31:16]) return 1'b0;
        end else if (!c[pb]) return 1'b0;
        if (!c[14]) begin
            if (c[3:2] == 2'd0) return !dout;
            if (c[3:2] == 2'd1) return dout;
            return 1'b1;
        end
        if (c[3:2] == 2'd2) return !dout && cls != 2'd2;
        if (c[3:2] == 2'd3) return !dout && cls == 2'd2;
        return 1'b0;
    endfunction

    task automatic run_hdr(input logic [31:0] c, input bit dout, input logic [1:0] cls,
                           input logic [PW-1:0] port, input logic [15:0] rid,
                           input string tag, input int stall_pct);
        logic [DW-1:0] w [MW];
        bit e;
        int n;
        for (int i = 0; i < MW; i++) begin
            w[i] = $urandom;
            hdr_words[i*DW +: DW] = w[i];
        end
        e = exp_pass(c, dout, cls, port, rid);
        @(negedge clk);
        cfg_ctrl = c; hdr_dir = dout; hdr_class = cls; hdr_port = port; hdr_rid = rid;
        hdr_valid = 1'b1;
        chk(hdr_ready == 1'b1, "R9 ready when idle", 32'(hdr_ready), 1);
        @(negedge clk);
        hdr_valid = 1'b0;
        cfg_ctrl  = $urandom;          // R10: config scrambled after accept
        hdr_words = {MW{32'hDEAD_BEEF}};
        chk(out_valid == e, tag, 32'(out_valid), 32'(e));
        if (e) begin
            n = c[14] ? MW : MW / 2;
            for (int i = 0; i < n; i++) begin
                while (int'($urandom % 100) < stall_pct) begin
                    out_ready = 1'b0;
                    @(negedge clk);
                    chk(out_valid && out_data == w[i], "R9 hold under stall", out_data, w[i]);
                end
                out_ready = 1'b1;
                chk(out_data == w[i], "R4 dword order", out_data, w[i]);
                chk(out_last == (i == n - 1), "R10 last marker", 32'(out_last), 32'(i == n - 1));
                @(negedge clk);
            end
            out_ready = 1'b0;
            chk(!out_valid && hdr_ready, "R10 back to idle", 32'(out_valid), 0);
        end
    endtask

    initial begin
        logic [31:0] c;
        logic [15:0] r;
        void'($urandom(32'd7151));
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 0);
        chk(hdr_ready == 1'b1, "R1 hdr_ready after reset", 32'(hdr_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && hdr_ready, "R1 idle after release", 32'(out_valid), 0);

        // port mask 0x0400 = port slot 5 (bit 10)
        run_hdr(32'h0400_0071, 1'b0, 2'd0, 4'd5, 16'h0, "R2 enabled pass", 30);
        run_hdr(32'h0400_0070, 1'b0, 2'd0, 4'd5, 16'h0, "R2 disabled drop", 0);
        run_hdr(32'h0400_0011, 1'b0, 2'd0, 4'd5, 16'h0, "R3 posted sel", 0);
        run_hdr(32'h0400_0021, 1'b0, 2'd0, 4'd5, 16'h0, "R3 posted unselected", 0);
        run_hdr(32'h0400_0071, 1'b0, 2'd2, 4'd5, 16'h0, "R3 completion multi", 0);
        run_hdr(32'h0400_00F1, 1'b0, 2'd1, 4'd5, 16'h0, "R3 bit7 set drop", 0);
        run_hdr(32'h0400_0071, 1'b0, 2'd3, 4'd5, 16'h0, "R3 class 3 drop", 0);
        run_hdr(32'h0400_4079, 1'b0, 2'd0, 4'd5, 16'h0, "R4 wide record", 40);
        run_hdr(32'hABCD_8071, 1'b0, 2'd1, 4'd0, 16'hABCD, "R5 rid match", 20);
        run_hdr(32'hABCD_8071, 1'b0, 2'd1, 4'd0, 16'hABCC, "R5 rid mismatch", 0);
        run_hdr(32'h0400_0071, 1'b0, 2'd0, 4'd13, 16'h0, "R6 port wraps to 5", 0);
        run_hdr(32'h0800_0071, 1'b0, 2'd0, 4'd5, 16'h0, "R6 odd bit no port", 0);
        run_hdr(32'h0400_0071, 1'b1, 2'd0, 4'd5, 16'h0, "R7 dir0 outbound drop", 0);
        run_hdr(32'h0400_0075, 1'b0, 2'd0, 4'd5, 16'h0, "R7 dir1 inbound drop", 0);
        run_hdr(32'h0400_0075, 1'b1, 2'd0, 4'd5, 16'h0, "R7 dir1 outbound pass", 0);
        run_hdr(32'h0400_0079, 1'b1, 2'd2, 4'd5, 16'h0, "R7 dir2 both", 0);
        run_hdr(32'h0400_4071, 1'b0, 2'd0, 4'd5, 16'h0, "R8 wide dir0 reserved", 0);
        run_hdr(32'h0400_4075, 1'b0, 2'd0, 4'd5, 16'h0, "R8 wide dir1 none", 0);
        run_hdr(32'h0400_4079, 1'b0, 2'd1, 4'd5, 16'h0, "R8 dir2 request", 0);
        run_hdr(32'h0400_4079, 1'b0, 2'd2, 4'd5, 16'h0, "R8 dir2 completion drop", 0);
        run_hdr(32'h0400_407D, 1'b0, 2'd2, 4'd5, 16'h0, "R8 dir3 completion", 0);
        run_hdr(32'h0400_407D, 1'b0, 2'd0, 4'd5, 16'h0, "R8 dir3 request drop", 0);
        run_hdr(32'h0400_407D, 1'b1, 2'd2, 4'd5, 16'h0, "R8 dir3 outbound drop", 0);

        for (int k = 0; k < 400; k++) begin
            c = $urandom;
            r = 16'($urandom);
            c[0] = ($urandom % 8) != 0;
            c[7] = ($urandom % 8) == 0;
            if (c[15] && ($urandom % 2) == 0) c[31:16] = r;
            if (!c[15]) c[31:16] = c[31:16] | 16'h5555 & 16'($urandom);
            run_hdr(c, 1'($urandom), 2'($urandom), PW'($urandom), r, "R7 random mix", 25);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule